// File: doc/BRIEF.md
# NAND Flash Host Register Front-End

This block connects a simple processor register bus to the pins of an 8-bit or 16-bit NAND flash device. Software writes commands, addresses and data words into registers. Each write is queued in a small write buffer, and a pin sequencer plays the queue out as strobed flash cycles. Command cycles raise the command-latch pin and address cycles raise the address-latch pin. The write strobe is held low for a programmable number of cycles. Every pin cycle ends with one hold cycle, in which the latch pins and the data bus stay as they were.

A single read has two phases. First, software writes any value to the read-request register. This queues a read-strobe cycle. When the captured word is ready, a sticky interrupt flag is set, and software then fetches the word from the read-data register. A status register shows the ready/busy pin, the fill state of the write buffer and the pending page transfers. A sticky interrupt register is cleared by writing 1 to a bit, and a mask register selects which sticky bits drive the interrupt output. A page-control register starts page transfers for an external transfer engine, which reports completion on a pulse input. A self-clearing reset register drives a clear pulse of fixed length to the error-code and counter logic.

Top module: `nand_host_regs`

## Requirements
- R1: After reset, the pins are idle (chip enable high, both strobes high, both latch pins low, data not driven). The status register (offset 1) reads 0x0011 when the ready/busy pin is high: bit 0 mirrors the ready/busy pin, bit 1 is buffer full, bit 2 is page write pending, bit 3 is page read pending and bit 4 is buffer empty. The sticky register (offset 2) reads 0, the mask register (offset 3) reads 0 and irq is low.
- R2: A write to offset 4 queues a command cycle, which holds the command-latch pin high. A write to offset 5 queues an address cycle, which holds the address-latch pin high. A write to offset 6 queues a data cycle, in which neither latch pin is high. In each of these cycles the write strobe stays low for wr_dly+1 clocks, with the word driven on the data pins. The control register is at offset 0: bit 0 selects the page size (1 = 512 bytes), bit 1 selects the 16-bit bus, bits 7:4 hold rd_dly and bits 11:8 hold wr_dly. The write strobe and the read strobe are never low together.
- R3: Queued cycles appear on the pins in the order in which they were written.
- R4: The write buffer holds 4 entries. Status bit 1 is set while the buffer is full. A queueing write that arrives while the buffer is full is dropped and sets sticky bit 1.
- R5: A write of any value to offset 7 queues a read cycle. In that cycle the read strobe stays low for rd_dly+1 clocks, and the data pins are sampled in the last clock of the strobe. When the word is captured, sticky bit 3 is set and the word can be read at offset 8.
- R6: With control bit 1 clear, the upper byte of each word driven to the data pins is forced to 0, and the upper byte of each captured read is forced to 0. With bit 1 set, all 16 bits pass through.
- R7: Writing 1 to a sticky bit clears it. Sticky bit 2 is set when the write buffer goes from non-empty to empty. Sticky bit 0 is set on a rising edge of the ready/busy pin.
- R8: irq is high exactly when some sticky bit is set and the same bit is set in the mask register.
- R9: Writing 1 to bit 0 at offset 9 raises ecc_clr for 3 clocks. During that time bit 0 reads back 1, and afterwards it reads back 0.
- R10: Writing offset 10 with bit 0 set sets status bit 3 and pulses page_rd_start. With bit 1 set, it sets status bit 2 and pulses page_wr_start. A xfer_done pulse clears both pending bits and sets sticky bit 4 if a page write was pending.
- R11: In the clock after a strobe rises, the latch pins, the chip enable and the data output stay unchanged (the hold cycle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write enable |
| bus_addr | input | 4 | Register word offset |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data for bus_addr |
| irq | output | 1 | Interrupt: OR of the masked sticky bits |
| page_rd_start | output | 1 | One-clock pulse that starts a page read |
| page_wr_start | output | 1 | One-clock pulse that starts a page write |
| xfer_done | input | 1 | Pulse from the transfer engine when a page transfer ends |
| ecc_clr | output | 1 | Clear for the error-code and counter logic |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cle | output | 1 | Command latch pin |
| nf_ale | output | 1 | Address latch pin |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_rb | input | 1 | Ready/busy pin, high = ready |
| nf_dq_o | output | 16 | Data pins, output value |
| nf_dq_oe | output | 1 | Data pin output enable |
| nf_dq_i | input | 16 | Data pins, input value |

## Verification
The bench builds the block with its default parameters: a 16-bit data path, a 4-entry buffer, 4-bit delay fields and a 3-clock reset pulse. The 4-bit write delay gives a maximum strobe of 16 clocks. That strobe is long enough for back-to-back bus writes to fill the buffer and reach the overflow drop while the first cycle is still on the pins. The 16-bit path makes the upper byte visible, so the bench can check that the 8-bit mode masks it, both on the pins and in the captured read word.

// File: rtl/nand_host_pkg.sv
package nand_host_pkg;

   // kind of queued pin cycle
   typedef enum logic [1:0] {
      OP_CMD  = 2'd0,
      OP_ADDR = 2'd1,
      OP_WR   = 2'd2,
      OP_RD   = 2'd3
   } nf_op_e;

   localparam int BUS_W = 16;

   // register word offsets
   localparam logic [3:0] A_CTRL  = 4'd0;
   localparam logic [3:0] A_STAT  = 4'd1;
   localparam logic [3:0] A_STICK = 4'd2;
   localparam logic [3:0] A_MASK  = 4'd3;
   localparam logic [3:0] A_CMD   = 4'd4;
   localparam logic [3:0] A_ADDR  = 4'd5;
   localparam logic [3:0] A_DWR   = 4'd6;
   localparam logic [3:0] A_DRD   = 4'd7;
   localparam logic [3:0] A_RDATA = 4'd8;
   localparam logic [3:0] A_CLR   = 4'd9;
   localparam logic [3:0] A_PAGE  = 4'd10;

   // sticky bit positions (software decodes them)
   localparam int S_NOTBUSY = 0;
   localparam int S_OVF     = 1;
   localparam int S_EDGE    = 2;
   localparam int S_RDRDY   = 3;
   localparam int S_WRDONE  = 4;
   localparam int NSTICK    = 5;

   // control register field positions
   localparam int C_PG512 = 0;
   localparam int C_WIDE  = 1;
   localparam int C_RDLY  = 4;
   localparam int C_WDLY  = 8;

endpackage

// File: rtl/nand_wbuf.sv
module nand_wbuf #(
   parameter int W     = 18,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic [W-1:0] pop_data,
   output logic         full,
   output logic         empty
);
   localparam int PW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("nand_wbuf: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign full     = (cnt == CW'(DEPTH));
   assign empty    = (cnt == '0);
   assign do_push  = push && !full;
   assign do_pop   = pop && !empty;
   assign pop_data = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   AST_WB_DROP_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> full); // R4
   AST_WB_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && !push) |=> empty); // R3

endmodule

// File: rtl/nand_pin_seq.sv
module nand_pin_seq
   import nand_host_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int DLY_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              avail,
   input  nf_op_e            op,
   input  logic [DATA_W-1:0] data,
   input  logic              wide,
   input  logic [DLY_W-1:0]  rd_dly,
   input  logic [DLY_W-1:0]  wr_dly,
   output logic              take,
   output logic              ce_n,
   output logic              cle,
   output logic              ale,
   output logic              we_n,
   output logic              re_n,
   output logic [DATA_W-1:0] dq_o,
   output logic              dq_oe,
   input  logic [DATA_W-1:0] dq_i,
   output logic              cap_valid,
   output logic [DATA_W-1:0] cap_data
);
   typedef enum logic [1:0] {ST_IDLE, ST_STRB, ST_HOLD} seq_st_e;

   seq_st_e           st;
   nf_op_e            cur_op;
   logic [DATA_W-1:0] cur_data;
   logic [DLY_W-1:0]  cnt;
   logic [DATA_W-1:0] out_narrow, in_narrow;

   // narrow-bus variant selection
   generate
      if (DATA_W > 8) begin : g_wide_path
         assign out_narrow = wide ? data : {{(DATA_W-8){1'b0}}, data[7:0]};
         assign in_narrow  = wide ? dq_i : {{(DATA_W-8){1'b0}}, dq_i[7:0]};
      end else begin : g_byte_path
         assign out_narrow = data;
         assign in_narrow  = dq_i;
      end
   endgenerate

   assign take = (st == ST_IDLE) && avail;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         cur_op    <= OP_CMD;
         cur_data  <= '0;
         cnt       <= '0;
         cap_valid <= 1'b0;
         cap_data  <= '0;
      end else begin
         cap_valid <= 1'b0;
         case (st)
            ST_IDLE: if (avail) begin
               st       <= ST_STRB;
               cur_op   <= op;
               cur_data <= out_narrow;
               cnt      <= (op == OP_RD) ? rd_dly : wr_dly;
            end
            ST_STRB: begin
               if (cnt == '0) begin
                  st <= ST_HOLD;
                  if (cur_op == OP_RD) begin
                     cap_valid <= 1'b1;
                     cap_data  <= in_narrow;
                  end
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign ce_n  = (st == ST_IDLE);
   assign cle   = (st != ST_IDLE) && (cur_op == OP_CMD);
   assign ale   = (st != ST_IDLE) && (cur_op == OP_ADDR);
   assign we_n  = !((st == ST_STRB) && (cur_op != OP_RD));
   assign re_n  = !((st == ST_STRB) && (cur_op == OP_RD));
   assign dq_oe = (st != ST_IDLE) && (cur_op != OP_RD);
   assign dq_o  = cur_data;

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(!we_n && !re_n)); // R2
   AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(cle && ale)); // R2
   AST_HOLD_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n) |-> (cle == $past(cle) && ale == $past(ale) && !ce_n && $stable(dq_o))); // R11
   AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !re_n |-> !dq_oe); // R5

endmodule

// File: rtl/nand_host_regs.sv
module nand_host_regs
   import nand_host_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int WB_DEPTH   = 4,
   parameter int DLY_W      = 4,
   parameter int RST_CYCLES = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [3:0]        bus_addr,
   input  logic [15:0]       bus_wdata,
   output logic [15:0]       bus_rdata,
   output logic              irq,
   output logic              page_rd_start,
   output logic              page_wr_start,
   input  logic              xfer_done,
   output logic              ecc_clr,
   output logic              nf_ce_n,
   output logic              nf_cle,
   output logic              nf_ale,
   output logic              nf_we_n,
   output logic              nf_re_n,
   input  logic              nf_rb,
   output logic [DATA_W-1:0] nf_dq_o,
   output logic              nf_dq_oe,
   input  logic [DATA_W-1:0] nf_dq_i
);
   localparam int EW  = 2 + DATA_W;
   localparam int RCW = $clog2(RST_CYCLES + 1);

   generate
      if (DATA_W != 8 && DATA_W != 16) begin : g_bad_width
         $error("nand_host_regs: DATA_W must be 8 or 16");
      end
      if (DLY_W < 1 || DLY_W > 4) begin : g_bad_dly
         $error("nand_host_regs: DLY_W must be 1..4");
      end
      if (RST_CYCLES < 2) begin : g_bad_rst
         $error("nand_host_regs: RST_CYCLES must be at least 2");
      end
   endgenerate

   logic [BUS_W-1:0]  ctrl_q;
   logic [NSTICK-1:0] stick_q, mask_q, stick_set;
   logic              rb_q, empty_q;
   logic              rd_pend, wr_pend;
   logic              clr_busy;
   logic [RCW-1:0]    clr_cnt;
   logic [DATA_W-1:0] rdat_q;

   logic              q_push, q_full, q_empty, q_take;
   nf_op_e            q_op;
   logic [EW-1:0]     q_in, q_out;
   logic              cap_valid;
   logic [DATA_W-1:0] cap_data;

   // decode of queueing writes
   always_comb begin
      q_push = 1'b0;
      q_op   = OP_CMD;
      if (bus_wr) begin
         case (bus_addr)
            A_CMD:   begin q_push = 1'b1; q_op = OP_CMD;  end
            A_ADDR:  begin q_push = 1'b1; q_op = OP_ADDR; end
            A_DWR:   begin q_push = 1'b1; q_op = OP_WR;   end
            A_DRD:   begin q_push = 1'b1; q_op = OP_RD;   end
            default: ;
         endcase
      end
   end
   assign q_in = {q_op, bus_wdata[DATA_W-1:0]};

   nand_wbuf #(.W(EW), .DEPTH(WB_DEPTH)) u_wbuf (
      .clk(clk), .rst_n(rst_n),
      .push(q_push), .push_data(q_in),
      .pop(q_take), .pop_data(q_out),
      .full(q_full), .empty(q_empty)
   );

   nand_pin_seq #(.DATA_W(DATA_W), .DLY_W(DLY_W)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .avail(!q_empty),
      .op(nf_op_e'(q_out[EW-1 -: 2])),
      .data(q_out[DATA_W-1:0]),
      .wide(ctrl_q[C_WIDE]),
      .rd_dly(ctrl_q[C_RDLY +: DLY_W]),
      .wr_dly(ctrl_q[C_WDLY +: DLY_W]),
      .take(q_take),
      .ce_n(nf_ce_n), .cle(nf_cle), .ale(nf_ale),
      .we_n(nf_we_n), .re_n(nf_re_n),
      .dq_o(nf_dq_o), .dq_oe(nf_dq_oe), .dq_i(nf_dq_i),
      .cap_valid(cap_valid), .cap_data(cap_data)
   );

   // sticky event sources
   always_comb begin
      stick_set            = '0;
      stick_set[S_NOTBUSY] = nf_rb && !rb_q;
      stick_set[S_OVF]     = q_push && q_full;
      stick_set[S_EDGE]    = q_empty && !empty_q;
      stick_set[S_RDRDY]   = cap_valid;
      stick_set[S_WRDONE]  = xfer_done && wr_pend;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q        <= BUS_W'(1) << C_PG512;
         stick_q       <= '0;
         mask_q        <= '0;
         rb_q          <= 1'b1;
         empty_q       <= 1'b1;
         rd_pend       <= 1'b0;
         wr_pend       <= 1'b0;
         page_rd_start <= 1'b0;
         page_wr_start <= 1'b0;
         clr_busy      <= 1'b0;
         clr_cnt       <= '0;
         rdat_q        <= '0;
      end else begin
         rb_q          <= nf_rb;
         empty_q       <= q_empty;
         page_rd_start <= 1'b0;
         page_wr_start <= 1'b0;

         if (bus_wr && bus_addr == A_CTRL) ctrl_q <= bus_wdata;
         if (bus_wr && bus_addr == A_MASK) mask_q <= bus_wdata[NSTICK-1:0];

         if (bus_wr && bus_addr == A_STICK)
            stick_q <= (stick_q & ~bus_wdata[NSTICK-1:0]) | stick_set;
         else
            stick_q <= stick_q | stick_set;

         if (cap_valid) rdat_q <= cap_data;

         if (xfer_done) begin
            rd_pend <= 1'b0;
            wr_pend <= 1'b0;
         end
         if (bus_wr && bus_addr == A_PAGE) begin
            if (bus_wdata[0]) begin
               rd_pend       <= 1'b1;
               page_rd_start <= 1'b1;
            end
            if (bus_wdata[1]) begin
               wr_pend       <= 1'b1;
               page_wr_start <= 1'b1;
            end
         end

         if (bus_wr && bus_addr == A_CLR && bus_wdata[0]) begin
            clr_busy <= 1'b1;
            clr_cnt  <= RCW'(RST_CYCLES - 1);
         end else if (clr_busy) begin
            if (clr_cnt == '0) clr_busy <= 1'b0;
            else               clr_cnt  <= clr_cnt - 1'b1;
         end
      end
   end

   assign ecc_clr = clr_busy;
   assign irq     = |(stick_q & mask_q);

   always_comb begin
      case (bus_addr)
         A_CTRL:  bus_rdata = ctrl_q;
         A_STAT:  bus_rdata = {11'b0, q_empty, rd_pend, wr_pend, q_full, nf_rb};
         A_STICK: bus_rdata = BUS_W'(stick_q);
         A_MASK:  bus_rdata = BUS_W'(mask_q);
         A_RDATA: bus_rdata = BUS_W'(rdat_q);
         A_CLR:   bus_rdata = BUS_W'(clr_busy);
         default: bus_rdata = '0;
      endcase
   end

   AST_IRQ_QUIET_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> !irq); // R8
   AST_OVF_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (q_push && q_full) |=> stick_q[S_OVF]); // R4
   AST_CLR_LASTS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clr_busy) |=> clr_busy); // R9
   AST_CAPTURE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      cap_valid |=> stick_q[S_RDRDY]); // R5

endmodule

// File: tb/tb_nand_host_regs.sv
module tb_nand_host_regs;
   import nand_host_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        irq, page_rd_start, page_wr_start, ecc_clr;
   logic        xfer_done = 1'b0;
   logic        nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
   logic        nf_rb = 1'b1;
   logic [15:0] nf_dq_o;
   logic [15:0] nf_dq_i = 16'hBEEF;

   int total = 0;
   int bad   = 0;
   int wr_pulses = 0;
   bit done_flag = 0;

   // expected pin cycles: {kind[1:0], len[5:0], data[15:0]}
   logic [23:0] exp_q[$];

   always #2 clk = ~clk;

   nand_host_regs dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
      .page_rd_start(page_rd_start), .page_wr_start(page_wr_start),
      .xfer_done(xfer_done), .ecc_clr(ecc_clr),
      .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale),
      .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_rb(nf_rb),
      .nf_dq_o(nf_dq_o), .nf_dq_oe(nf_dq_oe), .nf_dq_i(nf_dq_i)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [15:0] v);
      @(negedge clk);
      bus_addr = a;
      #1 v = bus_rdata;
   endtask

   // driver: queue a pin cycle and its expected item
   task automatic drive(input logic [3:0] a, input logic [15:0] d, input logic [1:0] kind,
                        input logic [15:0] expd, input int len, input bit accept);
      if (accept) exp_q.push_back({kind, 6'(len), expd});
      wr(a, d);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: measures each strobe and compares with the scoreboard
   int        lo_cnt = 0;
   logic [1:0] m_kind;
   logic [15:0] m_data;
   always @(negedge clk) begin
      if (rst_n) begin
         if (!nf_we_n || !nf_re_n) begin
            if (lo_cnt == 0) begin
               m_kind = nf_cle ? 2'd0 : nf_ale ? 2'd1 : !nf_re_n ? 2'd3 : 2'd2;
               m_data = nf_dq_o;
            end
            lo_cnt++;
         end else if (lo_cnt != 0) begin
            if (exp_q.size() == 0) begin
               chk(0, "R3 unexpected pin cycle", 32'(m_kind), 32'hFF);
            end else begin
               logic [23:0] e;
               e = exp_q.pop_front();
               chk(m_kind == e[23:22], "R2/R3 cycle kind", 32'(m_kind), 32'(e[23:22]));
               chk(lo_cnt == int'(e[21:16]), "R2/R5 strobe length", 32'(lo_cnt), 32'(e[21:16]));
               if (e[23:22] != 2'd3)
                  chk(m_data == e[15:0], "R2/R6 data on pins", 32'(m_data), 32'(e[15:0]));
               // hold cycle: latch pins and chip enable unchanged
               chk(nf_cle == (e[23:22] == 2'd0) && nf_ale == (e[23:22] == 2'd1) && !nf_ce_n,
                   "R11 hold cycle", {29'b0, nf_cle, nf_ale, nf_ce_n}, {29'b0, e[23:22] == 2'd0, e[23:22] == 2'd1, 1'b0});
            end
            lo_cnt = 0;
         end
      end
   end

   always @(posedge clk) if (rst_n && page_wr_start) wr_pulses++;

   initial begin
      repeat (100000) @(posedge clk);
      if (!done_flag) begin
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      chk(nf_ce_n && nf_we_n && nf_re_n && !nf_cle && !nf_ale && !nf_dq_oe, "R1 pins idle",
          {26'b0, nf_ce_n, nf_we_n, nf_re_n, nf_cle, nf_ale, nf_dq_oe}, 32'h38);
      rd(A_STAT, v);  chk(v == 16'h0011, "R1 status", 32'(v), 32'h11);
      rd(A_STICK, v); chk(v == 16'h0000, "R1 sticky", 32'(v), 32'h0);
      rd(A_MASK, v);  chk(v == 16'h0000, "R1 mask", 32'(v), 32'h0);
      chk(!irq, "R1 irq", 32'(irq), 32'h0);

      // R2 R3: 8-bit bus, wr_dly 2, rd_dly 1
      wr(A_CTRL, 16'h0211);
      drive(A_CMD,  16'h0090, 2'd0, 16'h0090, 3, 1);
      drive(A_ADDR, 16'h0000, 2'd1, 16'h0000, 3, 1);
      drive(A_DWR,  16'h01A5, 2'd2, 16'h00A5, 3, 1); // R6 upper byte masked
      idle(40);
      rd(A_STAT, v);  chk(v == 16'h0011, "R2 status idle again", 32'(v), 32'h11);
      rd(A_STICK, v); chk(v == 16'h0004, "R7 buffer-empty edge", 32'(v), 32'h4);
      wr(A_STICK, 16'h0004);
      rd(A_STICK, v); chk(v == 16'h0000, "R7 write-one clear", 32'(v), 32'h0);

      // R4 overflow: long strobe, six writes, fifth fills, sixth dropped
      wr(A_CTRL, 16'h0F11);
      for (int i = 0; i < 6; i++)
         drive(A_DWR, 16'h0011 + 16'(i), 2'd2, 16'h0011 + 16'(i), 16, i < 5);
      rd(A_STAT, v);  chk(v[1] == 1'b1, "R4 full flag", 32'(v), 32'h2);
      rd(A_STICK, v); chk(v[1] == 1'b1, "R4 overflow sticky", 32'(v), 32'h2);
      idle(120);
      rd(A_STAT, v);  chk(v == 16'h0011, "R4 drained", 32'(v), 32'h11);
      wr(A_STICK, 16'h001F);

      // R5 R6: 8-bit read, rd_dly 3
      wr(A_CTRL, 16'h0131);
      drive(A_DRD, 16'h0000, 2'd3, 16'h0000, 4, 1);
      begin
         int n = 0;
         v = 16'h0;
         while (n < 50 && v[3] == 1'b0) begin rd(A_STICK, v); n++; end
      end
      chk(v[3] == 1'b1, "R5 read ready", 32'(v), 32'h8);
      rd(A_RDATA, v); chk(v == 16'h00EF, "R6 narrow read", 32'(v), 32'hEF);
      wr(A_STICK, 16'h001F);

      // R6: 16-bit mode read and write
      wr(A_CTRL, 16'h0133);
      drive(A_DRD, 16'h5555, 2'd3, 16'h0000, 4, 1);
      drive(A_DWR, 16'h1234, 2'd2, 16'h1234, 2, 1);
      idle(30);
      rd(A_RDATA, v); chk(v == 16'hBEEF, "R6 wide read", 32'(v), 32'hBEEF);

      // R8 masking
      wr(A_MASK, 16'h0008);
      idle(1); chk(irq == 1'b1, "R8 irq on masked-in bit", 32'(irq), 32'h1);
      wr(A_MASK, 16'h0010);
      idle(1); chk(irq == 1'b0, "R8 irq off when masked out", 32'(irq), 32'h0);
      wr(A_STICK, 16'h001F);

      // R7 ready/busy rising edge
      @(negedge clk); nf_rb = 1'b0;
      idle(2);
      rd(A_STAT, v);  chk(v[0] == 1'b0, "R1 status mirrors busy", 32'(v), 32'h10);
      rd(A_STICK, v); chk(v[0] == 1'b0, "R7 no flag while busy", 32'(v), 32'h0);
      @(negedge clk); nf_rb = 1'b1;
      idle(2);
      rd(A_STICK, v); chk(v[0] == 1'b1, "R7 not-busy sticky", 32'(v), 32'h1);
      wr(A_MASK, 16'h0001);
      idle(1); chk(irq == 1'b1, "R8 irq from not-busy", 32'(irq), 32'h1);
      wr(A_STICK, 16'h001F);
      wr(A_MASK, 16'h0000);

      // R9 self-clearing reset
      wr(A_CLR, 16'h0001);
      rd(A_CLR, v); chk(v[0] == 1'b1, "R9 reads busy", 32'(v), 32'h1);
      chk(ecc_clr == 1'b1, "R9 clear active", 32'(ecc_clr), 32'h1);
      idle(5);
      rd(A_CLR, v); chk(v[0] == 1'b0, "R9 self cleared", 32'(v), 32'h0);
      chk(ecc_clr == 1'b0, "R9 clear released", 32'(ecc_clr), 32'h0);

      // R10 page control
      wr(A_PAGE, 16'h0002);
      rd(A_STAT, v); chk(v == 16'h0015, "R10 write pending", 32'(v), 32'h15);
      chk(wr_pulses == 1, "R10 write start pulse", 32'(wr_pulses), 32'h1);
      @(negedge clk); xfer_done = 1'b1;
      @(negedge clk); xfer_done = 1'b0;
      rd(A_STAT, v);  chk(v == 16'h0011, "R10 done clears", 32'(v), 32'h11);
      rd(A_STICK, v); chk(v[4] == 1'b1, "R10 write done sticky", 32'(v), 32'h10);
      wr(A_STICK, 16'h001F);
      wr(A_PAGE, 16'h0001);
      rd(A_STAT, v); chk(v == 16'h0019, "R10 read pending", 32'(v), 32'h19);
      @(negedge clk); xfer_done = 1'b1;
      @(negedge clk); xfer_done = 1'b0;
      rd(A_STICK, v); chk(v[4] == 1'b0, "R10 no write-done for read", 32'(v), 32'h0);
      rd(A_STAT, v);  chk(v == 16'h0011, "R10 read cleared", 32'(v), 32'h11);

      idle(5);
      chk(exp_q.size() == 0, "R3 all expected cycles seen", 32'(exp_q.size()), 32'h0);

      done_flag = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule